// File: doc/BRIEF.md
# Instruction-Driven Conversion Sequencer

This block runs analog-to-digital conversions from a short list of stored instructions. A host loads up to eight instruction words over a small register bus. It sets the run options in a control word and then starts the sequencer. For each instruction, the sequencer fetches the word and drives the selected channel onto a multiplexer-select output. It then times an acquisition window and a conversion window with internal counters. When the conversion window closes, the sequencer samples the converter's data port. It sign-extends the value to 16 bits and stores it in a 32-entry result FIFO.

The host pops results one at a time. An interrupt flag rises when the number of stored results reaches a programmable threshold. A DMA request flag stays high while results are waiting and DMA is enabled. The sequencer stops after the instruction marked last in single-pass mode, or returns to entry 0 in continuous mode. It never discards a result. When the FIFO is full, it waits in its store step until the host makes room.

Bus map: when address bit 3 is 0, a write loads instruction entry addr[2:0]. When address bit 3 is 1, a write updates the control word. Instruction word fields: bits [2:0] channel, bit 3 reduced resolution, bits [7:4] acquisition extension, bit 8 last. Control word fields: bit 0 start, bit 1 continuous, bit 2 DMA enable, bits [8:3] interrupt threshold.

Top module: `conv_seq`

## Requirements
- R1: After reset, busy, irq, dma_req, chan_sel and fifo_level are all 0.
- R2: While an instruction is acquired and converted, chan_sel carries that instruction's channel field (word bits [2:0]), and chan_sel holds that value after the result is stored.
- R3: A full-resolution instruction (bit 3 = 0) with extension 0 takes 56 cycles, from the clock edge that samples the start write to the edge that raises fifo_level. The steps are fetch 1, select 1, acquire 9, convert 44 and store 1.
- R4: A reduced-resolution instruction (bit 3 = 1) uses a 21-cycle conversion step, which gives 33 cycles with extension 0.
- R5: Each unit of the 4-bit extension field (word bits [7:4]) adds 2 cycles to the acquisition step.
- R6: In full-resolution mode, the 13-bit two's-complement value on conv_data is sign-extended from bit 12 into the 16-bit result.
- R7: In reduced-resolution mode, conv_data[8:0] is taken as a 9-bit two's-complement value and sign-extended from bit 8. Bits [12:9] are ignored.
- R8: Instructions run in order from entry 0. After the entry with bit 8 set, busy falls if the continuous bit (control bit 1) is 0; otherwise the sequencer returns to entry 0. Clearing the continuous bit lets the current pass finish and then stop.
- R9: The FIFO holds 32 results in arrival order. When it is full, the sequencer stalls with busy high until a pop frees a slot, and no result is lost.
- R10: irq is high exactly when the threshold (control bits [8:3]) is non-zero and fifo_level is at or above it.
- R11: dma_req is high exactly when DMA is enabled (control bit 2) and fifo_level is non-zero.
- R12: A pop while the FIFO is empty leaves rd_data and fifo_level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Write address: bit 3 selects the control word, bits [2:0] select an entry |
| host_wdata | input | 16 | Write data |
| host_rd | input | 1 | Pop one result from the FIFO |
| rd_data | output | 16 | Last popped result, valid the cycle after the pop |
| fifo_level | output | 6 | Number of stored results |
| conv_data | input | 13 | Converter output, sampled at the end of the conversion step |
| chan_sel | output | 3 | Multiplexer channel select |
| busy | output | 1 | Sequencer is running |
| irq | output | 1 | FIFO level has reached the threshold |
| dma_req | output | 1 | Results waiting, DMA enabled |

## Verification
The assertions assume that the host writes every instruction entry that a pass will fetch before it sets the start bit. They also assume that conv_data is stable when the conversion step ends. The bench writes all entries before each start and changes conv_data only while the sequencer is idle. The bench writes the control word while the sequencer runs only to clear the continuous bit. It pops during a stall only to release that stall.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SELECT, S_ACQ, S_CONV, S_STORE
  } seq_state_t;

  typedef struct packed {
    logic       last;
    logic [3:0] ext;
    logic       short_res;
    logic [2:0] chan;
  } instr_t;
endpackage

// File: rtl/cs_instr_mem.sv
module cs_instr_mem
  import conv_seq_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  instr_t        wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output instr_t        rdata
);
  instr_t mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cs_result_fifo.sv
module cs_result_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic [CW-1:0] thr,
  input  logic          dma_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          irq,
  output logic          dmarq
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;
  logic [CW-1:0] level_n;

  assign full    = (level == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (level != '0);

  always_comb begin
    level_n = level;
    if (do_push && !do_pop) level_n = level + 1'b1;
    if (do_pop && !do_push) level_n = level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (do_pop) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      irq   <= 1'b0;
      dmarq <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      level <= level_n;
      irq   <= (thr != '0) && (level_n >= thr);
      dmarq <= dma_en && (level_n != '0);
    end
  end

  // The sequencer must never offer a result while the FIFO is full (R9)
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);

  // A pop on an empty FIFO leaves the level at zero (R12)
  assert_empty_pop_R12: assert property (@(posedge clk) disable iff (rst)
    (pop && level == '0 && !push) |=> (level == '0));

  // DMA request follows enable and non-empty FIFO (R11)
  assert_dma_R11: assert property (@(posedge clk) disable iff (rst)
    dmarq |-> (level != '0));
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import conv_seq_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int DATA_W     = 16,
  parameter int ADC_W      = 13,
  parameter int SHORT_W    = 9,
  parameter int ACQ_BASE   = 9,
  parameter int CONV_FULL  = 44,
  parameter int CONV_SHORT = 21,
  localparam int AW      = $clog2(ENTRIES),
  localparam int ACQ_MAX = ACQ_BASE + 30,
  localparam int LEN_MAX = (ACQ_MAX > CONV_FULL) ? ACQ_MAX : CONV_FULL,
  localparam int CNT_W   = $clog2(LEN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              continuous,
  input  instr_t            instr,
  input  logic              fifo_full,
  input  logic [ADC_W-1:0]  conv_data,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic [2:0]        chan_sel,
  output logic              busy
);
  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] ext_full, ext_short;

  assign ext_full  = {{(DATA_W-ADC_W){conv_data[ADC_W-1]}}, conv_data};
  assign ext_short = {{(DATA_W-SHORT_W){conv_data[SHORT_W-1]}}, conv_data[SHORT_W-1:0]};

  assign rd_en     = (state == S_FETCH);
  assign push      = (state == S_STORE) && !fifo_full;
  assign push_data = sample;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      rd_addr  <= '0;
      cnt      <= '0;
      sample   <= '0;
      chan_sel <= '0;
      busy     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state   <= S_FETCH;
          rd_addr <= '0;
          busy    <= 1'b1;
        end
        S_FETCH: state <= S_SELECT;
        S_SELECT: begin
          chan_sel <= instr.chan;
          cnt      <= CNT_W'(ACQ_BASE - 1) + CNT_W'({instr.ext, 1'b0});
          state    <= S_ACQ;
        end
        S_ACQ: begin
          if (cnt == '0) begin
            cnt   <= instr.short_res ? CNT_W'(CONV_SHORT - 1) : CNT_W'(CONV_FULL - 1);
            state <= S_CONV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CONV: begin
          if (cnt == '0) begin
            sample <= instr.short_res ? ext_short : ext_full;
            state  <= S_STORE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_STORE: if (!fifo_full) begin
          if (instr.last && !continuous) begin
            state <= S_IDLE;
            busy  <= 1'b0;
          end else begin
            rd_addr <= instr.last ? '0 : rd_addr + 1'b1;
            state   <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Full FIFO holds the sequencer in its store step (R9)
  assert_store_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_STORE && fifo_full) |=> (state == S_STORE && busy));

  // Channel select is steady during conversion (R2)
  assert_chan_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_CONV && $past(state) == S_CONV) |-> $stable(chan_sel));

  // Acquisition only leaves towards conversion (R5)
  assert_acq_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACQ) |=> (state == S_ACQ || state == S_CONV));

  // Last instruction in single-pass mode ends the run (R8)
  assert_halt_R8: assert property (@(posedge clk) disable iff (rst)
    (push && instr.last && !continuous) |=> !busy);
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int NUM_INSTR  = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int DATA_W     = 16,
  parameter int ADC_W      = 13,
  parameter int SHORT_W    = 9,
  parameter int ACQ_BASE   = 9,
  parameter int CONV_FULL  = 44,
  parameter int CONV_SHORT = 21,
  localparam int IDX_W = $clog2(NUM_INSTR),
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int CTL_W = 3 + LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [IDX_W:0]    host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  fifo_level,
  input  logic [ADC_W-1:0]  conv_data,
  output logic [2:0]        chan_sel,
  output logic              busy,
  output logic              irq,
  output logic              dma_req
);
  logic              ctl_sel, go, cont_q, dma_en_q;
  logic [LVL_W-1:0]  thr_q;
  logic              rd_en, push, fifo_full;
  logic [IDX_W-1:0]  rd_addr;
  logic [DATA_W-1:0] push_data;
  instr_t            instr;
  logic              unused_wdata_hi;

  assign ctl_sel         = host_addr[IDX_W];
  assign go              = host_wr && ctl_sel && host_wdata[0];
  assign unused_wdata_hi = ^host_wdata[DATA_W-1:CTL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cont_q   <= 1'b0;
      dma_en_q <= 1'b0;
      thr_q    <= '0;
    end else if (host_wr && ctl_sel) begin
      cont_q   <= host_wdata[1];
      dma_en_q <= host_wdata[2];
      thr_q    <= host_wdata[CTL_W-1:3];
    end
  end

  cs_instr_mem #(.ENTRIES(NUM_INSTR)) u_mem (
    .clk(clk), .rst(rst),
    .we(host_wr && !ctl_sel), .waddr(host_addr[IDX_W-1:0]),
    .wdata(instr_t'(host_wdata[$bits(instr_t)-1:0])),
    .re(rd_en), .raddr(rd_addr), .rdata(instr)
  );

  cs_seq_fsm #(
    .ENTRIES(NUM_INSTR), .DATA_W(DATA_W), .ADC_W(ADC_W), .SHORT_W(SHORT_W),
    .ACQ_BASE(ACQ_BASE), .CONV_FULL(CONV_FULL), .CONV_SHORT(CONV_SHORT)
  ) u_fsm (
    .clk(clk), .rst(rst), .go(go), .continuous(cont_q), .instr(instr),
    .fifo_full(fifo_full), .conv_data(conv_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .push(push), .push_data(push_data),
    .chan_sel(chan_sel), .busy(busy)
  );

  cs_result_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop(host_rd), .thr(thr_q), .dma_en(dma_en_q), .rd_data(rd_data),
    .level(fifo_level), .full(fifo_full), .irq(irq), .dmarq(dma_req)
  );
endmodule

// File: tb/sim_conv_seq.sv
module sim_conv_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [12:0] conv_data = '0;
  logic [15:0] rd_data;
  logic [5:0]  fifo_level;
  logic [2:0]  chan_sel;
  logic        busy, irq, dma_req;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  conv_seq u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rd(host_rd), .rd_data(rd_data),
    .fifo_level(fifo_level), .conv_data(conv_data), .chan_sel(chan_sel),
    .busy(busy), .irq(irq), .dma_req(dma_req)
  );

  // {instruction word, conv_data, expected result, cycles to first result}
  localparam logic [52:0] VEC [7] = '{
    {16'h0103, 13'h0005, 16'h0005, 8'd56},
    {16'h0107, 13'h1FFF, 16'hFFFF, 8'd56},
    {16'h0150, 13'h1000, 16'hF000, 8'd66},
    {16'h0109, 13'h1EFF, 16'h00FF, 8'd33},
    {16'h013D, 13'h0100, 16'hFF00, 8'd39},
    {16'h01F2, 13'h0FFF, 16'h0FFF, 8'd86},
    {16'h01FE, 13'h01FF, 16'hFFFF, 8'd63}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pop();
    host_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_lvl(input int n, output int cyc);
    cyc = 0;
    while (fifo_level != 6'(n) && cyc < 5000) begin
      @(posedge clk); @(negedge clk); cyc++;
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500 && busy; k++) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 level", fifo_level, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 chan_sel", chan_sel, 0);

    // Single-instruction vectors: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 7; i++) begin
      wr(4'h0, VEC[i][52:37]);
      conv_data = VEC[i][36:24];
      wr(4'h8, 16'h0001);
      wait_lvl(1, c);
      chk("R3 R4 R5 cycles to result", c, VEC[i][7:0]);
      chk("R2 chan_sel", chan_sel, VEC[i][39:37]);
      chk("R8 halts after last", busy, 0);
      pop();
      chk("R6 R7 result", rd_data, VEC[i][23:8]);
    end

    // Three-entry single pass with irq threshold 2 and DMA on: R8 R10 R11
    wr(4'h0, 16'h0001);
    wr(4'h1, 16'h000A);
    wr(4'h2, 16'h0104);
    conv_data = 13'h0180;
    wr(4'h8, 16'h0015);
    wait_lvl(1, c);
    chk("R10 irq below threshold", irq, 0);
    chk("R11 dma_req with data", dma_req, 1);
    chk("R2 first channel", chan_sel, 1);
    wait_lvl(2, c);
    chk("R4 reduced step", c, 33);
    chk("R10 irq at threshold", irq, 1);
    wait_lvl(3, c);
    chk("R3 full step", c, 56);
    chk("R2 third channel", chan_sel, 4);
    repeat (5) begin @(posedge clk); @(negedge clk); end
    chk("R8 single pass stops", busy, 0);
    chk("R8 result count", fifo_level, 3);
    pop();
    chk("R8 order entry0", rd_data, 16'h0180);
    chk("R10 irq level 2", irq, 1);
    pop();
    chk("R8 order entry1", rd_data, 16'hFF80);
    chk("R10 irq clears below", irq, 0);
    pop();
    chk("R8 order entry2", rd_data, 16'h0180);
    chk("R11 dma_req empty", dma_req, 0);

    // Continuous wrap, then clear continuous: R8 R11
    wr(4'h0, 16'h0001);
    wr(4'h1, 16'h010A);
    wr(4'h8, 16'h0003);
    wait_lvl(4, c);
    wr(4'h8, 16'h0000);
    wait_idle();
    chk("R8 wrap then finish pass", fifo_level, 6);
    chk("R11 dma disabled", dma_req, 0);
    for (int k = 0; k < 6; k++) begin
      pop();
      chk("R8 wrap order", rd_data, (k % 2 == 0) ? 16'h0180 : 16'hFF80);
    end

    // Full FIFO stall and release: R9 R12
    wr(4'h0, 16'h0103);
    conv_data = 13'h0005;
    wr(4'h8, 16'h0007);
    wait_lvl(32, c);
    repeat (200) begin @(posedge clk); @(negedge clk); end
    chk("R9 level stays full", fifo_level, 32);
    chk("R9 stalled busy", busy, 1);
    wr(4'h8, 16'h0004);
    pop();
    chk("R9 head result", rd_data, 16'h0005);
    wait_idle();
    chk("R9 stalled result kept", fifo_level, 32);
    chk("R8 stops after release", busy, 0);
    for (int k = 0; k < 32; k++) begin
      pop();
      chk("R9 drained data", rd_data, 16'h0005);
    end
    chk("R9 empty after drain", fifo_level, 0);
    chk("R11 dma_req drops", dma_req, 0);
    pop();
    chk("R12 empty pop level", fifo_level, 0);
    chk("R12 empty pop data", rd_data, 16'h0005);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule